// File: doc/BRIEF.md
# Interrupt Source and Mask Register Pair

This block holds the eight status flags that a device controller's microcontroller polls or takes interrupts on, together with an eight-bit enable mask. Hardware event pulses set individual flags: a control-transfer SETUP arrival, an interrupt from the attached drive, completion of a read from buffer A or B, and completion of a write into buffer A or B. The top flag mirrors a USB-status summary input that is held elsewhere. Firmware clears flags by writing ones to the source address. Hardware can also clear the buffer flags: a write to an endpoint read-toggle control, or a clear request from the auto-transfer machine while auto-transfer mode is enabled.

A registered, active-high interrupt output is asserted whenever any flag is set and enabled in the mask. A repeated SETUP on a flag that is already set drops that flag for one cycle and then raises it again. This gives an edge-sensitive interrupt input a new rising edge. Both registers sit on a plain byte-wide bus with a combinational read path. There is no streaming data, so every pin is a plain control or status signal.

Top module: `isr_mask_regs`

## Requirements
- R1: After reset the source address reads 0x0C (with `usb_sum` low), the mask address reads 0x00, and `irq` is 0.
- R2: Source bit positions are: 7 USB summary, 6 SETUP, 5 reserved, 4 drive interrupt, 3 read-done B, 2 read-done A, 1 write-done B, 0 write-done A.
- R3: Source bit 7 always reads the current level of `usb_sum`. Bus writes to it have no effect.
- R4: Source bit 5 always reads 0.
- R5: A bus write to the source address returns each of bits 6..0 that has a 1 in the write data to its reset value (bits 3 and 2 become 1, the others 0). Bits written with 0 keep their value.
- R6: An event pulse sets its bit at the next clock edge. A set beats a same-cycle firmware write-1 and a same-cycle hardware clear.
- R7: A SETUP pulse while bit 6 is 1 makes bit 6 read 0 for exactly one cycle and then read 1 again.
- R8: A pulse on `tog_wr` with `tog_val`=1 clears bit 3, and with `tog_val`=0 clears bit 2. This hardware clear beats a same-cycle firmware write-1.
- R9: `auto_clr[1]` clears bit 1 and `auto_clr[0]` clears bit 0, only while `auto_en` is 1. While `auto_en` is 0, `auto_clr` has no effect.
- R10: The mask register is at 0x81 and is read/write. A mask bit of 1 enables the matching source bit.
- R11: `irq` equals the OR of (source view AND mask) as it stood one clock earlier.
- R12: During the one-cycle low of a repeated SETUP, `irq` deasserts one cycle later when no other enabled bit is set.
- R13: Reads from any address other than 0x80 and 0x81 return 0. Writes to such addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Combinational read data |
| usb_sum | input | 1 | USB-status summary level for bit 7 |
| ev_setup | input | 1 | SETUP received pulse |
| ev_drive | input | 1 | Drive interrupt pulse |
| ev_rd_b | input | 1 | Read from buffer B complete |
| ev_rd_a | input | 1 | Read from buffer A complete |
| ev_wr_b | input | 1 | Write into buffer B complete |
| ev_wr_a | input | 1 | Write into buffer A complete |
| tog_wr | input | 1 | Endpoint read-toggle written |
| tog_val | input | 1 | Value written to the read-toggle |
| auto_en | input | 1 | Auto-transfer mode enabled |
| auto_clr | input | 2 | Auto-transfer clear of write-done B (bit 1) and A (bit 0) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every write-1 pattern over bits 6..0. This catches a design that always clears to zero: it would leave the read-done bits at 0 where they must come back as 1. It sweeps all 256 mask values against a full source view, so a single miswired enable shows up as a wrong `irq`. It also drives collisions. A set event together with a write-1 must keep the bit set, and a design that lets the clear win loses the event. A toggle write together with a write-1 must leave the bit clear. `auto_clr` pulses while auto-transfer is disabled must change nothing. A repeated SETUP must produce exactly one low read and one low `irq` cycle. A design without the re-edge would hold `irq` high and never give an edge-triggered input a new edge.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned B_USB   = 7;
  localparam int unsigned B_SETUP = 6;
  localparam int unsigned B_RSV   = 5;
  localparam int unsigned B_DRV   = 4;
  localparam int unsigned B_RDB   = 3;
  localparam int unsigned B_RDA   = 2;
  localparam int unsigned B_WRB   = 1;
  localparam int unsigned B_WRA   = 0;
  localparam int unsigned N_PLAIN = 5;            // bits 4..0 share one cell type
  localparam logic [REG_W-1:0] SRC_RST = 8'h0C;
endpackage

// File: rtl/isr_cell.sv
module isr_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic fw_clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q_o <= RST_VAL;
    else if (set_i)    q_o <= 1'b1;
    else if (hw_clr_i) q_o <= 1'b0;
    else if (fw_clr_i) q_o <= RST_VAL;
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_hw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr_i && !set_i) |=> !q_o);
  p_fw_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_clr_i && !set_i && !hw_clr_i) |=> (q_o == RST_VAL));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_clr_i && !set_i && !hw_clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/isr_setup_cell.sv
module isr_setup_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic fw_clr_i,
  output logic q_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o    <= 1'b0;
      pend_q <= 1'b0;
    end else if (set_i && q_o) begin
      q_o    <= 1'b0;       // duplicate: drop for one cycle
      pend_q <= 1'b1;
    end else if (set_i || pend_q) begin
      q_o    <= 1'b1;
      pend_q <= 1'b0;
    end else if (fw_clr_i) begin
      q_o    <= 1'b0;
    end
  end

  p_dup_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && q_o) |=> !q_o);
  p_dup_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && q_o) |=> ##1 q_o);
  p_first_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !q_o) |=> q_o);
endmodule

// File: rtl/isr_mask_regs.sv
module isr_mask_regs
  import isr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 8'h80,
  parameter logic [ADDR_W-1:0] MSK_ADDR = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              usb_sum,
  input  logic              ev_setup,
  input  logic              ev_drive,
  input  logic              ev_rd_b,
  input  logic              ev_rd_a,
  input  logic              ev_wr_b,
  input  logic              ev_wr_a,
  input  logic              tog_wr,
  input  logic              tog_val,
  input  logic              auto_en,
  input  logic [1:0]        auto_clr,
  output logic              irq
);
  logic              wr_src, wr_msk;
  logic [N_PLAIN-1:0] plain_set, plain_hw, plain_q;
  logic              setup_q;
  logic [REG_W-1:0]  src_view, mask_q;

  assign wr_src = bus_wr && (bus_addr == SRC_ADDR);
  assign wr_msk = bus_wr && (bus_addr == MSK_ADDR);

  assign plain_set = {ev_drive, ev_rd_b, ev_rd_a, ev_wr_b, ev_wr_a};
  assign plain_hw  = {1'b0,
                      tog_wr && tog_val,
                      tog_wr && !tog_val,
                      auto_en && auto_clr[1],
                      auto_en && auto_clr[0]};

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_cell
    isr_cell #(.RST_VAL(SRC_RST[i])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (plain_set[i]),
      .hw_clr_i(plain_hw[i]),
      .fw_clr_i(wr_src && bus_wdata[i]),
      .q_o     (plain_q[i])
    );
  end

  isr_setup_cell u_setup (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ev_setup),
    .fw_clr_i(wr_src && bus_wdata[B_SETUP]),
    .q_o     (setup_q)
  );

  assign src_view = {usb_sum, setup_q, 1'b0, plain_q};

  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_msk) mask_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(src_view & mask_q);
  end

  always_comb begin
    if (bus_addr == SRC_ADDR)      bus_rdata = src_view;
    else if (bus_addr == MSK_ADDR) bus_rdata = mask_q;
    else                           bus_rdata = '0;
  end

  p_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SRC_ADDR) |-> (bus_rdata[B_RSV] == 1'b0));
  p_usb_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SRC_ADDR) |-> (bus_rdata[B_USB] == usb_sum));
  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msk |=> (mask_q == $past(bus_wdata)));
  p_irq_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_view & mask_q)) |=> irq);
  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(src_view & mask_q)) |=> !irq);
  p_other_addr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr != SRC_ADDR) && (bus_addr != MSK_ADDR)) |-> (bus_rdata == '0));
endmodule

// File: tb/test_isr_mask_regs.sv
module test_isr_mask_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_SRC = 8'h80;
  localparam logic [7:0] A_MSK = 8'h81;
  localparam logic [7:0] RSTV  = 8'h0C;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, usb_sum = 0;
  logic ev_setup = 0, ev_drive = 0, ev_rd_b = 0, ev_rd_a = 0, ev_wr_b = 0, ev_wr_a = 0;
  logic tog_wr = 0, tog_val = 0, auto_en = 0;
  logic [1:0] auto_clr = 0;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_mask_regs i_isr_mask_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .usb_sum(usb_sum),
    .ev_setup(ev_setup), .ev_drive(ev_drive), .ev_rd_b(ev_rd_b), .ev_rd_a(ev_rd_a),
    .ev_wr_b(ev_wr_b), .ev_wr_a(ev_wr_a), .tog_wr(tog_wr), .tog_val(tog_val),
    .auto_en(auto_en), .auto_clr(auto_clr), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, held across posedge, released at next negedge
  task automatic tick();
    @(posedge clk); @(negedge clk);
    bus_wr = 0; ev_setup = 0; ev_drive = 0; ev_rd_b = 0; ev_rd_a = 0;
    ev_wr_b = 0; ev_wr_a = 0; tog_wr = 0; auto_clr = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic all_events();
    ev_setup = 1; ev_drive = 1; ev_rd_b = 1; ev_rd_a = 1; ev_wr_b = 1; ev_wr_a = 1; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);

    // R1 reset state
    rd(A_SRC, d); chk("R1 src", d, RSTV);
    rd(A_MSK, d); chk("R1 mask", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R13 other address read and write
    rd(8'h82, d); chk("R13 read other", d, 8'h00);
    wr(8'h7F, 8'hFF);
    rd(A_SRC, d); chk("R13 src untouched", d, RSTV);
    rd(A_MSK, d); chk("R13 mask untouched", d, 8'h00);

    // R3 bit 7 mirror, writes ignored
    usb_sum = 1; rd(A_SRC, d); chk("R3 mirror high", d, RSTV | 8'h80);
    wr(A_SRC, 8'h80); rd(A_SRC, d); chk("R3 write ignored", d, RSTV | 8'h80);
    usb_sum = 0; rd(A_SRC, d); chk("R3 mirror low", d, RSTV);

    // R2 R4 R5 R6: sweep every write-1 pattern over bits 6..0
    for (int v = 0; v < 128; v++) begin
      wr(A_SRC, 8'hFF);
      all_events();
      rd(A_SRC, d); chk("R2 R6 all set", d, 8'h5F);
      wr(A_SRC, v[7:0]);
      exp = (8'h5F & ~v[7:0]) | (RSTV & v[7:0]);
      exp[5] = 1'b0;
      rd(A_SRC, d); chk("R5 R4 write-1 restore", d, exp);
    end

    // R10 R11: full mask sweep against source 0xDF
    wr(A_SRC, 8'hFF); all_events(); usb_sum = 1;
    for (int m = 0; m < 256; m++) begin
      wr(A_MSK, m[7:0]);
      rd(A_MSK, d); chk("R10 mask readback", d, m[7:0]);
      tick();
      chk("R11 irq", {7'b0, irq}, {7'b0, |(8'hDF & m[7:0])});
    end
    usb_sum = 0;

    // R6 set beats write-1 in same cycle
    wr(A_SRC, 8'hFF);                       // source 0x0C
    ev_drive = 1; wr(A_SRC, 8'h10);
    rd(A_SRC, d); chk("R6 set beats write", d, 8'h1C);
    // R6 set beats toggle clear
    ev_rd_b = 1; tog_wr = 1; tog_val = 1; tick();
    rd(A_SRC, d); chk("R6 set beats hw clear", d, 8'h1C);

    // R8 toggle clears, beats write-1
    tog_wr = 1; tog_val = 1; wr(A_SRC, 8'h08);
    rd(A_SRC, d); chk("R8 toggle 1 clears bit3", d, 8'h14);
    tog_wr = 1; tog_val = 0; tick();
    rd(A_SRC, d); chk("R8 toggle 0 clears bit2", d, 8'h10);

    // R9 auto clear gated by mode
    ev_wr_a = 1; ev_wr_b = 1; tick();
    auto_en = 0; auto_clr = 2'b11; tick();
    rd(A_SRC, d); chk("R9 disabled no effect", d, 8'h13);
    auto_en = 1; auto_clr = 2'b10; tick();
    rd(A_SRC, d); chk("R9 clears bit1", d, 8'h11);
    auto_clr = 2'b01; tick();
    rd(A_SRC, d); chk("R9 clears bit0", d, 8'h10);
    auto_en = 0;

    // R7 R12 duplicate SETUP re-edge
    wr(A_SRC, 8'hFF);                       // source 0x0C
    wr(A_MSK, 8'h40);
    ev_setup = 1; tick();
    rd(A_SRC, d); chk("R7 first setup", d, 8'h4C);
    tick(); chk("R12 irq high", {7'b0, irq}, 8'h01);
    ev_setup = 1; tick();
    rd(A_SRC, d); chk("R7 drop", d, 8'h0C);
    chk("R12 irq still high", {7'b0, irq}, 8'h01);
    tick();
    rd(A_SRC, d); chk("R7 return", d, 8'h4C);
    chk("R12 irq low", {7'b0, irq}, 8'h00);
    tick(); chk("R12 irq re-rise", {7'b0, irq}, 8'h01);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule